// File: doc/BRIEF.md
# Control and Status Register Access Unit

This unit carries out the six control-register instructions of a RISC-V hart (swap, bit-set and bit-clear, each with a register or a 5-bit immediate source) against a small bank of registers. The decoder presents `funct3`, the destination index, the source index (which doubles as the immediate), the 12-bit register address, the source register value and the current privilege level. In the same cycle the unit returns the prior register value for the destination write-back, a read strobe, a write strobe with the final stored value, an illegal-instruction flag and a request to flush younger instructions.

Whether an access reads and whether it writes is set by the instruction form and by the destination and source index fields alone, never by comparing new and old values. A swap into `x0` skips the read, and a set or clear with a zero source index skips the write. Access rights come from the address itself: bits [9:8] hold the minimum privilege and bits [11:10] equal to 3 mark a read-only register. The bank holds the floating-point flag, rounding-mode and combined registers, a scratch register, a trap-vector base, the address-translation register and a read-only hart identifier.

Top module: `csr_access_unit`

## Requirements
- R1: The unit is active only when `valid` is high and `funct3` is 001 (swap), 010 (set), 011 (clear), 101 (swap immediate), 110 (set immediate) or 111 (clear immediate); otherwise every output is zero.
- R2: A swap form with `rd` equal to 0 does not read: `csr_re` is 0 and `rd_data` is 0, while the write still happens.
- R3: A set or clear form with the `rs1` field equal to 0 does not write (`csr_we` is 0) whatever the source register value, and still reads and returns the current value.
- R4: A write is decided only by form and fields: a swap that stores the value already held still raises `csr_we`.
- R5: Privilege is encoded 0 user, 1 supervisor, 3 machine; an access with `priv` below address bits [9:8] raises `illegal`.
- R6: An address with bits [11:10] equal to 3 is read-only: an access that would write raises `illegal`, one that does not write is legal. Address 0xF14 reads the `HART_ID` parameter.
- R7: Address 0x003 reads the 5-bit flags (0x001) in bits [4:0] and the 3-bit rounding mode (0x002) in bits [7:5]; a write to 0x003 updates both fields.
- R8: A legal access to the translation register at 0x180 raises `flush`; no other access does.
- R9: The immediate forms use the `rs1` field zero-extended as the operand and ignore `rs1_val`.
- R10: Swap stores the operand, set stores old OR operand, clear stores old AND NOT operand; the result is ANDed with the register's writable mask (0x305 has bits [1:0] fixed at 0, 0x001 has 5 bits, 0x002 has 3 bits, 0x003 has 8 bits; 0x340 and 0x180 are full width) and presented on `csr_wdata`.
- R11: An address outside the bank raises `illegal`; on any fault `csr_we`, `csr_re` and `rd_we` are 0 and no register changes.
- R12: `rd_we` is 1 only when `rd` is nonzero and the access does not fault; `rd_data` carries the value read.
- R13: All registers reset to 0; a write becomes visible to an access in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid | input | 1 | Instruction present |
| funct3 | input | 3 | Instruction form |
| rd | input | 5 | Destination index |
| rs1 | input | 5 | Source index or immediate |
| csr_addr | input | 12 | Register address |
| rs1_val | input | XLEN | Source register value |
| priv | input | 2 | Current privilege level |
| rd_data | output | XLEN | Prior register value for write-back |
| rd_we | output | 1 | Destination write-back enable |
| csr_re | output | 1 | Register read performed |
| csr_we | output | 1 | Register write performed |
| csr_wdata | output | XLEN | Value stored by the write |
| illegal | output | 1 | Illegal-instruction fault |
| flush | output | 1 | Refetch younger instructions |

## Verification
Every output is a combinational function of the current instruction and the stored bank, so it is due in the cycle the instruction is presented; the bench drives on the falling edge and samples one nanosecond later, before the next rising edge. Register contents change only at that rising edge, so effects of a write, or the absence of one after a fault or a suppressed write, are checked by a read issued in the next cycle.

// File: rtl/csr_access_unit.sv
module csr_access_unit #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] HART_ID = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [2:0]      funct3,
  input  logic [4:0]      rd,
  input  logic [4:0]      rs1,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [1:0]      priv,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_we,
  output logic            csr_re,
  output logic            csr_we,
  output logic [XLEN-1:0] csr_wdata,
  output logic            illegal,
  output logic            flush
);
  localparam logic [11:0] A_FLAGS = 12'h001;
  localparam logic [11:0] A_RMODE = 12'h002;
  localparam logic [11:0] A_FPCTL = 12'h003;
  localparam logic [11:0] A_XLAT  = 12'h180;
  localparam logic [11:0] A_TVEC  = 12'h305;
  localparam logic [11:0] A_SCR   = 12'h340;
  localparam logic [11:0] A_HART  = 12'hF14;
  localparam logic [XLEN-1:0] ONES = '1;

  logic [4:0]      flags_q;
  logic [2:0]      rmode_q;
  logic [XLEN-1:0] xlat_q, tvec_q, scr_q;

  logic            known;
  logic [XLEN-1:0] cur, wmask, operand, old, nv;

  wire [1:0] kind     = funct3[1:0];
  wire       is_swap  = kind == 2'b01;
  wire       active   = valid && kind != 2'b00;
  wire       do_read  = !(is_swap && rd == 5'd0);
  wire       do_write = is_swap || rs1 != 5'd0;
  wire       low_priv = priv < csr_addr[9:8];
  wire       ro       = csr_addr[11:10] == 2'b11;
  wire       fault    = active && (!known || low_priv || (ro && do_write));
  wire       ok       = active && !fault;

  always_comb begin
    known = 1'b1;
    cur   = '0;
    wmask = '0;
    case (csr_addr)
      A_FLAGS: begin cur = XLEN'(flags_q); wmask = XLEN'(5'h1F); end
      A_RMODE: begin cur = XLEN'(rmode_q); wmask = XLEN'(3'h7); end
      A_FPCTL: begin cur = XLEN'({rmode_q, flags_q}); wmask = XLEN'(8'hFF); end
      A_XLAT:  begin cur = xlat_q; wmask = ONES; end
      A_TVEC:  begin cur = tvec_q; wmask = ONES << 2; end
      A_SCR:   begin cur = scr_q;  wmask = ONES; end
      A_HART:  cur = HART_ID;
      default: known = 1'b0;
    endcase
  end

  assign operand = funct3[2] ? XLEN'(rs1) : rs1_val;
  assign old     = do_read ? cur : '0;

  always_comb begin
    case (kind)
      2'b10:   nv = old | operand;
      2'b11:   nv = old & ~operand;
      default: nv = operand;
    endcase
  end

  assign illegal   = fault;
  assign csr_re    = ok && do_read;
  assign csr_we    = ok && do_write;
  assign rd_we     = ok && rd != 5'd0;
  assign rd_data   = csr_re ? cur : '0;
  assign csr_wdata = csr_we ? (nv & wmask) : '0;
  assign flush     = ok && csr_addr == A_XLAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      rmode_q <= '0;
      xlat_q  <= '0;
      tvec_q  <= '0;
      scr_q   <= '0;
    end else if (csr_we) begin
      case (csr_addr)
        A_FLAGS: flags_q <= csr_wdata[4:0];
        A_RMODE: rmode_q <= csr_wdata[2:0];
        A_FPCTL: begin
          flags_q <= csr_wdata[4:0];
          rmode_q <= csr_wdata[7:5];
        end
        A_XLAT:  xlat_q <= csr_wdata;
        A_TVEC:  tvec_q <= csr_wdata;
        A_SCR:   scr_q  <= csr_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csr_access_checker.sv
module csr_access_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid,
  input logic [2:0]      funct3,
  input logic [4:0]      rd,
  input logic [4:0]      rs1,
  input logic [11:0]     csr_addr,
  input logic [1:0]      priv,
  input logic [XLEN-1:0] rd_data,
  input logic            rd_we,
  input logic            csr_re,
  input logic            csr_we,
  input logic [XLEN-1:0] csr_wdata,
  input logic            illegal,
  input logic            flush
);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid || funct3[1:0] == 2'b00) |-> !(csr_re || csr_we || rd_we || illegal || flush));

  assert_swap_x0_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && funct3[1:0] == 2'b01 && rd == 5'd0) |-> !csr_re);

  assert_zero_src_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && funct3[1] && rs1 == 5'd0) |-> !csr_we);

  assert_priv_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && funct3[1:0] != 2'b00 && priv < csr_addr[9:8]) |-> illegal);

  assert_readonly_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && csr_addr[11:10] == 2'b11 && (funct3[1:0] == 2'b01 || (funct3[1] && rs1 != 5'd0)))
      |-> illegal);

  assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !(csr_we || csr_re || rd_we || flush));

  assert_wb_needs_rd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> rd != 5'd0);

  assert_flush_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> csr_addr == 12'h180);

  assert_scratch_persist_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 12'h340) |=>
      ((csr_re && csr_addr == 12'h340) ? rd_data == $past(csr_wdata) : 1'b1));
endmodule

bind csr_access_unit csr_access_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .funct3(funct3), .rd(rd), .rs1(rs1),
  .csr_addr(csr_addr), .priv(priv), .rd_data(rd_data), .rd_we(rd_we),
  .csr_re(csr_re), .csr_we(csr_we), .csr_wdata(csr_wdata),
  .illegal(illegal), .flush(flush)
);

// File: tb/test_csr_access_unit.sv
module test_csr_access_unit;
  localparam int XLEN = 32;
  localparam logic [31:0] HID = 32'h7;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic [2:0] funct3 = '0;
  logic [4:0] rd = '0, rs1 = '0;
  logic [11:0] csr_addr = '0;
  logic [31:0] rs1_val = '0;
  logic [1:0] priv = 2'd3;
  logic [31:0] rd_data, csr_wdata;
  logic rd_we, csr_re, csr_we, illegal, flush;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  csr_access_unit #(.XLEN(XLEN), .HART_ID(HID)) i_csr_access_unit (
    .clk(clk), .rst_n(rst_n), .valid(valid), .funct3(funct3), .rd(rd), .rs1(rs1),
    .csr_addr(csr_addr), .rs1_val(rs1_val), .priv(priv), .rd_data(rd_data),
    .rd_we(rd_we), .csr_re(csr_re), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .illegal(illegal), .flush(flush)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] f, input logic [4:0] d, input logic [4:0] s,
                       input logic [11:0] a, input logic [31:0] v, input logic [1:0] p);
    @(negedge clk);
    valid = 1'b1; funct3 = f; rd = d; rs1 = s; csr_addr = a; rs1_val = v; priv = p;
    #1;
  endtask

  task automatic read_expect(input string req, input logic [11:0] a, input logic [31:0] exp);
    issue(3'b010, 5'd1, 5'd0, a, 32'hFFFF_FFFF, 2'd3);
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    read_expect("R13 reset scratch", 12'h340, 32'h0);
    read_expect("R13 reset fpctl", 12'h003, 32'h0);
    read_expect("R6 hart id", 12'hF14, HID);
  endtask

  task automatic t_inactive;
    issue(3'b000, 5'd1, 5'd1, 12'h340, 32'h5, 2'd3);
    check("R1 f3=000", {rd_we, csr_re, csr_we, illegal, flush}, 0);
    issue(3'b100, 5'd1, 5'd1, 12'h7C0, 32'h5, 2'd0);
    check("R1 f3=100", {rd_we, csr_re, csr_we, illegal, flush}, 0);
    @(negedge clk); valid = 1'b0; funct3 = 3'b001; #1;
    check("R1 not valid", {rd_we, csr_re, csr_we, illegal, flush}, 0);
  endtask

  task automatic t_ops;
    issue(3'b001, 5'd1, 5'd2, 12'h340, 32'h0000_A5A5, 2'd3);
    check("R10 swap old", rd_data, 32'h0);
    check("R10 swap wdata", csr_wdata, 32'h0000_A5A5);
    check("R12 swap rd_we", {rd_we, csr_we}, 2'b11);
    issue(3'b010, 5'd1, 5'd2, 12'h340, 32'h0000_0F0F, 2'd3);
    check("R13 set old", rd_data, 32'h0000_A5A5);
    check("R10 set wdata", csr_wdata, 32'h0000_AFAF);
    issue(3'b011, 5'd1, 5'd2, 12'h340, 32'h0000_00FF, 2'd3);
    check("R10 clear wdata", csr_wdata, 32'h0000_AF00);
    issue(3'b001, 5'd1, 5'd2, 12'h305, 32'hFFFF_FFFF, 2'd3);
    check("R10 tvec mask", csr_wdata, 32'hFFFF_FFFC);
    read_expect("R10 tvec stored", 12'h305, 32'hFFFF_FFFC);
  endtask

  task automatic t_same_value;
    issue(3'b001, 5'd3, 5'd2, 12'h340, 32'h0000_AF00, 2'd3);
    check("R4 unchanged write", {csr_we, illegal}, 2'b10);
    check("R4 wdata", csr_wdata, 32'h0000_AF00);
  endtask

  task automatic t_no_write;
    issue(3'b010, 5'd1, 5'd0, 12'h340, 32'hFFFF_FFFF, 2'd3);
    check("R3 set x0 no write", {csr_we, csr_re}, 2'b01);
    check("R3 set x0 read", rd_data, 32'h0000_AF00);
    issue(3'b111, 5'd2, 5'd0, 12'h340, 32'hFFFF_FFFF, 2'd3);
    check("R3 clri 0 no write", {csr_we, csr_re}, 2'b01);
    read_expect("R3 unchanged", 12'h340, 32'h0000_AF00);
  endtask

  task automatic t_no_read;
    issue(3'b001, 5'd0, 5'd4, 12'h340, 32'h0000_1234, 2'd3);
    check("R2 no read", {csr_re, csr_we, rd_we}, 3'b010);
    check("R2 rd_data zero", rd_data, 32'h0);
    read_expect("R2 write landed", 12'h340, 32'h0000_1234);
    issue(3'b101, 5'd0, 5'd9, 12'h340, 32'h0, 2'd3);
    check("R2 swapi no read", {csr_re, csr_we}, 2'b01);
  endtask

  task automatic t_imm;
    issue(3'b101, 5'd1, 5'h15, 12'h340, 32'hFFFF_FFFF, 2'd3);
    check("R9 swapi operand", csr_wdata, 32'h15);
    issue(3'b110, 5'd1, 5'h0A, 12'h340, 32'hFFFF_FFFF, 2'd3);
    check("R9 seti old", rd_data, 32'h15);
    check("R9 seti wdata", csr_wdata, 32'h1F);
    issue(3'b111, 5'd1, 5'h03, 12'h340, 32'h0, 2'd3);
    check("R9 clri wdata", csr_wdata, 32'h1C);
  endtask

  task automatic t_faults;
    issue(3'b001, 5'd1, 5'd2, 12'h340, 32'h0000_DEAD, 2'd0);
    check("R5 user scratch", illegal, 1'b1);
    check("R11 no effects", {csr_we, csr_re, rd_we}, 3'b000);
    read_expect("R11 scratch kept", 12'h340, 32'h1C);
    issue(3'b010, 5'd1, 5'd0, 12'h7C0, 32'h0, 2'd3);
    check("R11 unknown addr", {illegal, rd_we}, 2'b10);
    issue(3'b010, 5'd1, 5'd0, 12'h340, 32'h0, 2'd1);
    check("R5 supervisor scratch", illegal, 1'b1);
    issue(3'b001, 5'd1, 5'd2, 12'h180, 32'h8000_0001, 2'd0);
    check("R5 user xlat", {illegal, flush}, 2'b10);
  endtask

  task automatic t_readonly;
    issue(3'b001, 5'd1, 5'd2, 12'hF14, HID, 2'd3);
    check("R6 ro swap same value", {illegal, csr_we}, 2'b10);
    issue(3'b110, 5'd1, 5'd0, 12'hF14, 32'h0, 2'd3);
    check("R6 ro seti 0 legal", {illegal, csr_re}, 2'b01);
    check("R6 ro read value", rd_data, HID);
  endtask

  task automatic t_fp;
    issue(3'b001, 5'd1, 5'd2, 12'h003, 32'hFFFF_FFFF, 2'd0);
    check("R7 fpctl wdata", csr_wdata, 32'hFF);
    read_expect("R7 flags", 12'h001, 32'h1F);
    read_expect("R7 rmode", 12'h002, 32'h7);
    issue(3'b101, 5'd1, 5'd2, 12'h002, 32'h0, 2'd0);
    check("R7 rmode old", rd_data, 32'h7);
    read_expect("R7 composite", 12'h003, 32'h5F);
  endtask

  task automatic t_flush;
    issue(3'b001, 5'd1, 5'd2, 12'h180, 32'h8000_0001, 2'd1);
    check("R8 xlat flush", {flush, illegal}, 2'b10);
    issue(3'b010, 5'd1, 5'd0, 12'h180, 32'h0, 2'd3);
    check("R8 xlat read flush", flush, 1'b1);
    check("R8 xlat value", rd_data, 32'h8000_0001);
    issue(3'b010, 5'd1, 5'd0, 12'h340, 32'h0, 2'd3);
    check("R8 no flush scratch", flush, 1'b0);
    issue(3'b010, 5'd0, 5'd0, 12'h340, 32'h0, 2'd3);
    check("R12 rd x0 no wb", {rd_we, csr_re}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_inactive;
    t_ops;
    t_same_value;
    t_no_write;
    t_no_read;
    t_imm;
    t_faults;
    t_readonly;
    t_fp;
    t_flush;
    @(negedge clk); valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule